// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of a group of attached devices onto a small number of shared interrupt lines. Every device has four pins. Each pin is routed to one output line by a fixed rotation that depends on the device's slot and the pin number. Devices placed behind a bridge are rotated a second time by the bridge's own slot before they reach the shared lines.

Each output line has an up/down counter. The counter goes up when a source mapped to that line rises and down when one falls. The block keeps the last level it sampled on every pin, so a pin that is held at a steady level is counted only once. Changes on several pins that arrive in the same cycle are added together per line before the counter is updated. A line is driven high while its counter is nonzero, so each output is the OR of all the sources routed to it.

A system integrator instantiates the block with the number of devices, the number of lines, the index of the first bridged device and the bridge slot. The devices' pin levels are connected to it, and the line outputs go to the interrupt controller.

Top module: `intx_aggregator`

## Requirements
- R1: The pin vector holds four bits per device: device d, pin p (0 to 3) is bit 4*d+p, and a 1 means the pin is asserting.
- R2: A device with index below BRIDGE_FIRST drives output line (d + p) mod LINES.
- R3: A device with index d at or above BRIDGE_FIRST first maps to k = ((d - BRIDGE_FIRST) + p) mod LINES. It then drives line (BRIDGE_SLOT + k) mod LINES.
- R4: An output line is high exactly when at least one source routed to it is high.
- R5: The outputs follow the pin levels sampled at the most recent rising clock edge, so a pin change shows on the line one cycle later and not before that edge.
- R6: A pin held at the same level over many cycles adds nothing further, so the outputs stay unchanged while the inputs are steady.
- R7: One source on a line may fall in the same cycle that another source on that line rises. The changes are summed, so the line stays high with no glitch.
- R8: A line counter never exceeds the number of sources and never wraps below zero. Raising all sources and then dropping them all leaves every line low.
- R9: A synchronous active-high reset clears every counter and every stored pin level. The lines read low while reset is held. Pins still high when reset is released are counted fresh in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| devPins | input | NUM_DEV*4 | Interrupt pin levels; device d pin p at bit 4*d+p |
| lineOut | output | LINES | Shared interrupt line levels |

## Verification
The bench drives each of the 32 sources alone. A wrong rotation, or a bridge stage that is left out or applied twice, lights a line other than the expected one. It swaps two sources on the same line in a single cycle. A design that applies only one change per cycle would drop the line or leave it stuck high. It holds inputs steady for several cycles to expose re-counting of held levels, which would push counters up until a line stayed high after release. It also releases reset with every pin high, which catches stored state that is not cleared: that state would either miss the fresh rises or drive a counter below zero on the next release.

// File: rtl/intx_pkg.sv
package intx_pkg;

  localparam int unsigned PINS_PER_DEV = 4;

  // Per-source change strobes handed from control to datapath
  typedef struct packed {
    logic rise;
    logic fall;
  } srcStrobe_t;

  // Pin-to-line rotation, with an optional second stage for bridged devices
  function automatic int unsigned lineOf(input int unsigned dev,
                                         input int unsigned pin,
                                         input int unsigned lines,
                                         input int unsigned bridgeFirst,
                                         input int unsigned bridgeSlot);
    int unsigned stage1;
    if (dev >= bridgeFirst) begin
      stage1 = ((dev - bridgeFirst) + pin) % lines;
      return (bridgeSlot + stage1) % lines;
    end
    return (dev + pin) % lines;
  endfunction

endpackage

// File: rtl/intx_ctrl.sv
module intx_ctrl
  import intx_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              pinLevel,
  output srcStrobe_t [NUM_SRC-1:0]        strobe
);

  logic [NUM_SRC-1:0] lastLevel;

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= '0;
    else     lastLevel <= pinLevel;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      strobe[s].rise = !rst &&  pinLevel[s] && !lastLevel[s];
      strobe[s].fall = !rst && !pinLevel[s] &&  lastLevel[s];
    end
  end

endmodule

// File: rtl/intx_datapath.sv
module intx_datapath
  import intx_pkg::*;
#(
  parameter int unsigned NUM_DEV     = 8,
  parameter int unsigned LINES       = 4,
  parameter int unsigned BRIDGE_FIRST = 6,
  parameter int unsigned BRIDGE_SLOT = 1,
  parameter int unsigned CW          = 6
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  srcStrobe_t [NUM_DEV*PINS_PER_DEV-1:0]  strobe,
  output logic [LINES-1:0][CW-1:0]               lineCnt,
  output logic [LINES-1:0]                       lineOut
);

  localparam int unsigned NUM_SRC = NUM_DEV * PINS_PER_DEV;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [CW-1:0] upSum;
    logic [CW-1:0] dnSum;

    always_comb begin
      upSum = '0;
      dnSum = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (lineOf(s / PINS_PER_DEV, s % PINS_PER_DEV, LINES,
                   BRIDGE_FIRST, BRIDGE_SLOT) == l) begin
          upSum = upSum + CW'(strobe[s].rise);
          dnSum = dnSum + CW'(strobe[s].fall);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) lineCnt[l] <= '0;
      else     lineCnt[l] <= lineCnt[l] + upSum - dnSum;
    end

    assign lineOut[l] = (lineCnt[l] != '0);
  end

endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_pkg::*;
#(
  parameter int unsigned NUM_DEV      = 8,
  parameter int unsigned LINES        = 4,
  parameter int unsigned BRIDGE_FIRST = 6,
  parameter int unsigned BRIDGE_SLOT  = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] devPins,
  output logic [LINES-1:0]                lineOut
);

  localparam int unsigned NUM_SRC = NUM_DEV * PINS_PER_DEV;
  localparam int unsigned CW      = $clog2(NUM_SRC + 1);

  srcStrobe_t [NUM_SRC-1:0]  strobe;
  logic [LINES-1:0][CW-1:0]  lineCnt;

  intx_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pinLevel (devPins),
    .strobe   (strobe)
  );

  intx_datapath #(
    .NUM_DEV      (NUM_DEV),
    .LINES        (LINES),
    .BRIDGE_FIRST (BRIDGE_FIRST),
    .BRIDGE_SLOT  (BRIDGE_SLOT),
    .CW           (CW)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .lineCnt (lineCnt),
    .lineOut (lineOut)
  );

endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk #(
  parameter int unsigned LINES   = 4,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned CW      = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_SRC-1:0]        devPins,
  input logic [LINES-1:0]          lineOut,
  input logic [LINES-1:0][CW-1:0]  lineCnt
);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> lineOut == '0);

  // R6
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(devPins) && !$past(rst)) |=> $stable(lineOut));

  // R4
  all_low_chk: assert property (@(posedge clk) disable iff (rst)
    (devPins == '0) |=> (lineOut == '0));

  for (genvar l = 0; l < LINES; l++) begin : g_bound
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      lineCnt[l] <= CW'(NUM_SRC));
  end

endmodule

bind intx_aggregator intx_aggregator_chk #(
  .LINES   (LINES),
  .NUM_SRC (NUM_SRC),
  .CW      (CW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .devPins (devPins),
  .lineOut (lineOut),
  .lineCnt (lineCnt)
);

// File: tb/test_intx_aggregator.sv
module test_intx_aggregator;

  localparam int NUM_DEV      = 8;
  localparam int LINES        = 4;
  localparam int BRIDGE_FIRST = 6;
  localparam int BRIDGE_SLOT  = 1;
  localparam int NSRC         = NUM_DEV * 4;

  logic clk = 1'b0;
  always #4ns clk = ~clk;

  logic              rst;
  logic [NSRC-1:0]   devPins;
  logic [LINES-1:0]  lineOut;

  intx_aggregator #(
    .NUM_DEV(NUM_DEV), .LINES(LINES),
    .BRIDGE_FIRST(BRIDGE_FIRST), .BRIDGE_SLOT(BRIDGE_SLOT)
  ) i_intx_aggregator (
    .clk(clk), .rst(rst), .devPins(devPins), .lineOut(lineOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cycNum = 0;
  always @(posedge clk) cycNum++;

  typedef struct {
    logic [LINES-1:0] exp;
    int               stamp;
    string            req;
  } item_t;
  item_t q[$];

  function automatic int tbLine(int d, int p);
    if (d >= BRIDGE_FIRST) return (BRIDGE_SLOT + ((d - BRIDGE_FIRST + p) % LINES)) % LINES;
    return (d + p) % LINES;
  endfunction

  function automatic logic [LINES-1:0] tbExpect(logic [NSRC-1:0] v);
    logic [LINES-1:0] e = '0;
    for (int d = 0; d < NUM_DEV; d++)
      for (int p = 0; p < 4; p++)
        if (v[4*d+p]) e[tbLine(d, p)] = 1'b1;
    return e;
  endfunction

  task automatic check(string req, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: lineOut=%b expected %b (cycle %0d)", req, act, exp, cycNum);
    end
  endtask

  // driver: apply a pin vector and queue its expected line levels
  task automatic drive(logic [NSRC-1:0] v, string req);
    @(negedge clk);
    devPins = v;
    q.push_back('{tbExpect(v), cycNum, req});
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare one cycle after each applied vector
  always @(negedge clk) begin
    item_t it;
    if (q.size() != 0 && q[0].stamp < cycNum) begin
      it = q.pop_front();
      check(it.req, lineOut, it.exp);
    end
  end

  initial begin
    #1600us;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run hung, got no end expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1;
    devPins = '0;
    repeat (3) @(negedge clk);
    check("R9", lineOut, '0);
    rst = 1'b0;

    // R1 R2 R3: every source alone, then released (R4)
    for (int s = 0; s < NSRC; s++) begin
      drive(NSRC'(1) << s, (s / 4 >= BRIDGE_FIRST) ? "R1 R3" : "R1 R2");
      drive('0, "R4");
    end
    drain();

    // R5: no change before the sampling edge
    @(negedge clk);
    devPins = NSRC'(32'h0000_0001);
    #1ns;
    check("R5", lineOut, '0);
    q.push_back('{tbExpect(devPins), cycNum, "R5"});

    // R6: steady levels over several cycles
    drive(NSRC'(32'h0000_0011), "R6");
    repeat (4) drive(NSRC'(32'h0000_0011), "R6");
    drive('0, "R6");

    // R7: same-line fall and rise in one cycle
    drive(NSRC'(32'h0000_0001), "R7");   // dev0 pin0 -> line0
    drive(NSRC'(32'h0000_0080), "R7");   // dev1 pin3 -> line0
    drive(NSRC'(32'h0000_0002), "R7");   // dev0 pin1 -> line1
    drive(NSRC'(32'h0100_0000), "R7");   // dev6 pin0 -> line1 via bridge
    drive('0, "R7");

    // R8: all sources up then down, repeated
    for (int k = 0; k < 3; k++) begin
      drive('1, "R8");
      drive('1, "R8");
      drive('0, "R8");
    end

    // R4: pseudo-random patterns
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(NSRC'(lfsr), "R4");
    end
    drive('0, "R4");
    drain();

    // R9: reset with pins held high, then release
    drive('1, "R9");
    drain();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", lineOut, '0);
    @(negedge clk);
    check("R9", lineOut, '0);
    rst = 1'b0;
    q.push_back('{tbExpect(devPins), cycNum, "R9"});
    drive(NSRC'(32'h0000_0F00), "R9");
    drive('0, "R9");
    drain();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule